// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block holds the 64-bit compare value that supervisor software programs to schedule its next timer interrupt. It compares that value against a free-running 64-bit time input every clock and drives a registered supervisor timer-pending output. The pending output is set while the compare value is at or below the current time and cleared otherwise. Software therefore never sets or clears the pending bit directly. It moves the compare value instead.

The unit decodes two CSR addresses. 0x14D holds the whole value, or its low half on a 32-bit core. 0x15D holds the high half and exists only on a 32-bit core. Each access is checked against four things: whether the feature is present, whether a time source is present, the current privilege level, and two enable bits set by machine mode. A failed check raises an illegal-access flag and has no effect on the register.

The unit also filters the write mask that machine software applies to the interrupt-pending register. This keeps such writes from overriding the two timer-pending bits while the compare logic owns them.

Top module: `stcmp_top`

## Requirements
- R1: After reset the compare value is zero. A legal read of 0x14D in 64-bit mode returns all 64 bits. Addresses other than 0x14D and 0x15D never raise the illegal flag.
- R2: Any access to 0x14D or 0x15D is illegal while the feature enable or the time-source-present input is low.
- R3: Machine mode (privilege code 2'b11) may always access the register. A lower level may access it only when both the counter-enable timer bit and the environment timer-compare enable bit are set, and only if the level is not user (2'b00). Supervisor is 2'b01. All other cases are illegal.
- R4: In 64-bit mode, a write to 0x14D replaces all 64 bits.
- R5: In 32-bit mode, a write to 0x14D replaces bits 31:0 and keeps bits 63:32. A read of 0x14D returns bits 31:0, zero-extended.
- R6: In 32-bit mode, a write to 0x15D replaces bits 63:32 with write-data bits 31:0 and keeps bits 31:0. A read of 0x15D returns bits 63:32 in read-data bits 31:0. In 64-bit mode, any access to 0x15D is illegal.
- R7: The pending output is a register. At each clock edge it loads the result of an unsigned 64-bit test, compare value <= time. A compare value in the past therefore raises pending on the edge after the write edge.
- R8: When the compare value is above the time, pending stays low. It rises on the first edge at which the time input equals or exceeds the compare value.
- R9: The unit passes the interrupt-pending write mask through unchanged, except in one case. When the feature is enabled, the privilege is machine and the environment timer-compare enable is set, mask bit 5 (supervisor timer) and bit 6 (virtual supervisor timer) are forced to zero.
- R10: An illegal access leaves the compare value unchanged and returns read data of zero.
- R11: While reset is asserted, the pending output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| isRv32 | input | 1 | 1 selects 32-bit behaviour, 0 selects 64-bit |
| privLvl | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| featEn | input | 1 | Timer-compare feature present |
| timeValid | input | 1 | A time source is present |
| cntEnTm | input | 1 | Counter-enable timer bit set by machine mode |
| envStce | input | 1 | Environment-config timer-compare enable bit |
| csrAddr | input | 12 | CSR address |
| csrRd | input | 1 | Read strobe |
| csrWr | input | 1 | Write strobe |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Read data, zero when not a legal read of this unit |
| csrIllegal | output | 1 | Access to this unit is not permitted |
| timeNow | input | 64 | Current time value |
| timerPend | output | 1 | Registered supervisor timer-pending bit |
| mipMaskIn | input | 16 | Requested interrupt-pending write mask |
| mipMaskOut | output | 16 | Mask after timer-bit gating |

## Verification
Two functions can land in the same cycle: a CSR write of a new compare value, and the time input reaching the old value. The bench first arranges that time equals the current compare value, so pending is high. In that same cycle it writes a compare value in the future. The bench then requires pending to drop on the edge after the write edge, because the new value is what counts. It also requires pending to rise again on the edge that samples a time equal to the new value.

// File: rtl/stcmp_pkg.sv
package stcmp_pkg;
  localparam logic [11:0] ADDR_CMP_LO = 12'h14D;
  localparam logic [11:0] ADDR_CMP_HI = 12'h15D;
  localparam int STIP_BIT  = 5;
  localparam int VSTIP_BIT = 6;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } privLvl_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_ALL  = 2'd1,
    RD_LO   = 2'd2,
    RD_HI   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrAll;
    logic   wrLo;
    logic   wrHi;
    rdSel_e rdSel;
  } cmpStrobe_t;
endpackage

// File: rtl/stcmp_ctrl.sv
module stcmp_ctrl
  import stcmp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int MIP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isRv32,
  input  logic [1:0]        privLvl,
  input  logic              featEn,
  input  logic              timeValid,
  input  logic              cntEnTm,
  input  logic              envStce,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrRd,
  input  logic              csrWr,
  output logic              csrIllegal,
  output cmpStrobe_t        stb,
  input  logic [MIP_W-1:0]  mipMaskIn,
  output logic [MIP_W-1:0]  mipMaskOut
);
  logic hitLo, hitHi, hitAny, accReq;
  logic extOk, privOk, widthOk, legal, isMach;
  logic [MIP_W-1:0] timerBits;

  assign hitLo  = (csrAddr == ADDR_W'(ADDR_CMP_LO));
  assign hitHi  = (csrAddr == ADDR_W'(ADDR_CMP_HI));
  assign hitAny = hitLo | hitHi;
  assign accReq = csrRd | csrWr;
  assign isMach = (privLvl == PRIV_M);

  // Access rules: feature + time source, then privilege, then width.
  assign extOk   = featEn & timeValid;
  assign privOk  = isMach | (cntEnTm & envStce & (privLvl != PRIV_U));
  assign widthOk = ~hitHi | isRv32;
  assign legal   = extOk & privOk & widthOk;

  assign csrIllegal = accReq & hitAny & ~legal;

  always_comb begin
    stb = '{wrAll: 1'b0, wrLo: 1'b0, wrHi: 1'b0, rdSel: RD_NONE};
    if (legal) begin
      if (csrWr) begin
        stb.wrAll = hitLo & ~isRv32;
        stb.wrLo  = hitLo &  isRv32;
        stb.wrHi  = hitHi;
      end
      if (csrRd) begin
        if (hitLo)      stb.rdSel = isRv32 ? RD_LO : RD_ALL;
        else if (hitHi) stb.rdSel = RD_HI;
      end
    end
  end

  // Software may not touch the timer-pending bits while the compare owns them.
  always_comb begin
    timerBits = '0;
    timerBits[STIP_BIT]  = 1'b1;
    timerBits[VSTIP_BIT] = 1'b1;
    if (featEn && isMach && envStce) mipMaskOut = mipMaskIn & ~timerBits;
    else                             mipMaskOut = mipMaskIn;
  end

  // R6
  hi_rv64_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accReq && hitHi && !isRv32) |-> csrIllegal);

  // R3
  user_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accReq && hitAny && privLvl == PRIV_U) |-> csrIllegal);

  // R10
  illegal_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csrIllegal |-> (!stb.wrAll && !stb.wrLo && !stb.wrHi && stb.rdSel == RD_NONE));

  // R9
  mip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (featEn && privLvl == PRIV_M && envStce) |->
      (!mipMaskOut[STIP_BIT] && !mipMaskOut[VSTIP_BIT]));
endmodule

// File: rtl/stcmp_dpath.sv
module stcmp_dpath
  import stcmp_pkg::*;
#(
  parameter int CMP_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmpStrobe_t       stb,
  input  logic [CMP_W-1:0] csrWdata,
  output logic [CMP_W-1:0] csrRdata,
  input  logic [CMP_W-1:0] timeNow,
  output logic             timerPend
);
  localparam int HALF_W = CMP_W / 2;

  logic [CMP_W-1:0] cmpReg, cmpNext;
  logic             dueNow;

  always_comb begin
    cmpNext = cmpReg;
    if (stb.wrAll)     cmpNext = csrWdata;
    else if (stb.wrLo) cmpNext = {cmpReg[CMP_W-1:HALF_W], csrWdata[HALF_W-1:0]};
    else if (stb.wrHi) cmpNext = {csrWdata[HALF_W-1:0], cmpReg[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmpReg <= '0;
    else        cmpReg <= cmpNext;
  end

  // Unsigned compare, evaluated every cycle.
  assign dueNow = (cmpReg <= timeNow);

  always_ff @(posedge clk) begin
    if (!rst_n) timerPend <= 1'b0;
    else        timerPend <= dueNow;
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_ALL:  csrRdata = cmpReg;
      RD_LO:   csrRdata = {{HALF_W{1'b0}}, cmpReg[HALF_W-1:0]};
      RD_HI:   csrRdata = {{HALF_W{1'b0}}, cmpReg[CMP_W-1:HALF_W]};
      default: csrRdata = '0;
    endcase
  end

  // R5
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrLo |=> cmpReg[CMP_W-1:HALF_W] == $past(cmpReg[CMP_W-1:HALF_W]));

  // R6
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrHi |=> cmpReg[HALF_W-1:0] == $past(cmpReg[HALF_W-1:0]));

  // R7
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpReg <= timeNow) |=> timerPend);

  // R8
  pend_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpReg > timeNow) |=> !timerPend);
endmodule

// File: rtl/stcmp_top.sv
module stcmp_top
  import stcmp_pkg::*;
#(
  parameter int CMP_W  = 64,
  parameter int ADDR_W = 12,
  parameter int MIP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isRv32,
  input  logic [1:0]        privLvl,
  input  logic              featEn,
  input  logic              timeValid,
  input  logic              cntEnTm,
  input  logic              envStce,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrRd,
  input  logic              csrWr,
  input  logic [CMP_W-1:0]  csrWdata,
  output logic [CMP_W-1:0]  csrRdata,
  output logic              csrIllegal,
  input  logic [CMP_W-1:0]  timeNow,
  output logic              timerPend,
  input  logic [MIP_W-1:0]  mipMaskIn,
  output logic [MIP_W-1:0]  mipMaskOut
);
  cmpStrobe_t stb;

  stcmp_ctrl #(.ADDR_W(ADDR_W), .MIP_W(MIP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .isRv32(isRv32), .privLvl(privLvl),
    .featEn(featEn), .timeValid(timeValid), .cntEnTm(cntEnTm),
    .envStce(envStce), .csrAddr(csrAddr), .csrRd(csrRd), .csrWr(csrWr),
    .csrIllegal(csrIllegal), .stb(stb),
    .mipMaskIn(mipMaskIn), .mipMaskOut(mipMaskOut)
  );

  stcmp_dpath #(.CMP_W(CMP_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .timeNow(timeNow), .timerPend(timerPend)
  );

  // R11
  reset_pend_chk: assert property (@(posedge clk)
    !rst_n |=> !timerPend);
endmodule

// File: tb/sim_stcmp_top.sv
module sim_stcmp_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        isRv32;
  logic [1:0]  privLvl;
  logic        featEn, timeValid, cntEnTm, envStce;
  logic [11:0] csrAddr;
  logic        csrRd, csrWr;
  logic [63:0] csrWdata, csrRdata;
  logic        csrIllegal;
  logic [63:0] timeNow;
  logic        timerPend;
  logic [15:0] mipMaskIn, mipMaskOut;

  stcmp_top u0 (
    .clk(clk), .rst_n(rst_n), .isRv32(isRv32), .privLvl(privLvl),
    .featEn(featEn), .timeValid(timeValid), .cntEnTm(cntEnTm),
    .envStce(envStce), .csrAddr(csrAddr), .csrRd(csrRd), .csrWr(csrWr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .csrIllegal(csrIllegal),
    .timeNow(timeNow), .timerPend(timerPend),
    .mipMaskIn(mipMaskIn), .mipMaskOut(mipMaskOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          sel;   // 0 rdata, 1 illegal, 2 pend, 3 mip mask
    logic [63:0] exp;
    string       tag;
  } sbItem_t;

  sbItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      sbItem_t it;
      logic [63:0] act;
      it = expQ.pop_front();
      case (it.sel)
        0: act = csrRdata;
        1: act = {63'd0, csrIllegal};
        2: act = {63'd0, timerPend};
        default: act = {48'd0, mipMaskOut};
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expectVal(input int sel, input logic [63:0] v, input string tag);
    sbItem_t it;
    it.sel = sel; it.exp = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [63:0] d,
                         input logic expIll, input string tag);
    csrAddr = a; csrWdata = d; csrWr = 1'b1;
    expectVal(1, {63'd0, expIll}, tag);
    tick();
    csrWr = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a, input logic [63:0] expD,
                        input logic expIll, input string tag);
    csrAddr = a; csrRd = 1'b1;
    expectVal(0, expD, tag);
    expectVal(1, {63'd0, expIll}, tag);
    tick();
    csrRd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; isRv32 = 1'b0; privLvl = 2'b11;
    featEn = 1'b1; timeValid = 1'b1; cntEnTm = 1'b0; envStce = 1'b0;
    csrAddr = 12'h000; csrRd = 1'b0; csrWr = 1'b0; csrWdata = '0;
    timeNow = '0; mipMaskIn = 16'hFFFF;
    tick();
    expectVal(2, 64'd0, "R11 pend low in reset");
    tick();
    tick();
    rst_n = 1'b1;

    // R1 reset value and foreign address
    doRead(12'h14D, 64'd0, 1'b0, "R1 reset value");
    doRead(12'h140, 64'd0, 1'b0, "R1 foreign address");

    // R2 feature / time source gating
    featEn = 1'b0;
    doRead(12'h14D, 64'd0, 1'b1, "R2 feature off");
    featEn = 1'b1; timeValid = 1'b0;
    doRead(12'h14D, 64'd0, 1'b1, "R2 no time source");
    timeValid = 1'b1;

    // R3 privilege combinations
    privLvl = 2'b01; cntEnTm = 1'b1; envStce = 1'b0;
    doRead(12'h14D, 64'd0, 1'b1, "R3 S tm only");
    cntEnTm = 1'b0; envStce = 1'b1;
    doRead(12'h14D, 64'd0, 1'b1, "R3 S stce only");
    cntEnTm = 1'b1;
    doRead(12'h14D, 64'd0, 1'b0, "R3 S both set");
    privLvl = 2'b00;
    doRead(12'h14D, 64'd0, 1'b1, "R3 U both set");
    privLvl = 2'b11; cntEnTm = 1'b0; envStce = 1'b0;
    doRead(12'h14D, 64'd0, 1'b0, "R3 M always");

    // R4 full write in 64-bit mode; far-future value keeps pend low
    timeNow = 64'd1000;
    doWrite(12'h14D, 64'h1122334455667788, 1'b0, "R4 write");
    doRead(12'h14D, 64'h1122334455667788, 1'b0, "R4 readback");

    // R6 high half illegal in 64-bit mode
    doWrite(12'h15D, 64'd0, 1'b1, "R6 rv64 hi write illegal");
    doRead(12'h14D, 64'h1122334455667788, 1'b0, "R10 unchanged after illegal");

    // R5 / R6 split halves in 32-bit mode
    isRv32 = 1'b1;
    doWrite(12'h14D, 64'hFFFFFFFF_AABBCCDD, 1'b0, "R5 lo write");
    doRead(12'h14D, 64'h00000000_AABBCCDD, 1'b0, "R5 lo read");
    doRead(12'h15D, 64'h00000000_11223344, 1'b0, "R5 hi kept");
    doWrite(12'h15D, 64'hDEADBEEF_99887766, 1'b0, "R6 hi write");
    doRead(12'h15D, 64'h00000000_99887766, 1'b0, "R6 hi read");
    doRead(12'h14D, 64'h00000000_AABBCCDD, 1'b0, "R6 lo kept");

    // R10 illegal user write has no effect
    privLvl = 2'b00;
    doWrite(12'h14D, 64'd0, 1'b1, "R10 user write");
    privLvl = 2'b11;
    doRead(12'h14D, 64'h00000000_AABBCCDD, 1'b0, "R10 lo unchanged");
    isRv32 = 1'b0;

    // R7 compare in the past; unsigned top-bit value stays in the future
    doWrite(12'h14D, 64'd500, 1'b0, "R7 past write");
    tick();
    expectVal(2, 64'd1, "R7 pend after past write");
    doWrite(12'h14D, 64'h8000000000000000, 1'b0, "R7 unsigned write");
    tick();
    expectVal(2, 64'd0, "R7 unsigned compare keeps pend low");

    // R8 future compare, rises exactly when time arrives
    timeNow = 64'd1995;
    doWrite(12'h14D, 64'd2000, 1'b0, "R8 future write");
    tick();
    expectVal(2, 64'd0, "R8 low before due");
    timeNow = 64'd1999;
    tick();
    expectVal(2, 64'd0, "R8 low one before due");
    timeNow = 64'd2000;
    tick();
    expectVal(2, 64'd1, "R8 high at due");

    // Same-cycle: write a future value while time sits on the old one
    doWrite(12'h14D, 64'd3000, 1'b0, "R7 set 3000");
    timeNow = 64'd3000;
    tick();
    expectVal(2, 64'd1, "R7 pend at 3000");
    doWrite(12'h14D, 64'd5000, 1'b0, "R8 rewrite while due");
    tick();
    expectVal(2, 64'd0, "R8 new value wins");
    timeNow = 64'd5000;
    tick();
    expectVal(2, 64'd1, "R8 due at 5000");

    // R9 mip mask gating
    privLvl = 2'b11; envStce = 1'b1; featEn = 1'b1;
    #1 expectVal(3, 64'h0000_0000_0000_FF9F, "R9 gated in M with stce");
    tick();
    envStce = 1'b0;
    #1 expectVal(3, 64'h0000_0000_0000_FFFF, "R9 open without stce");
    tick();
    privLvl = 2'b01; envStce = 1'b1;
    #1 expectVal(3, 64'h0000_0000_0000_FFFF, "R9 open in S");
    tick();
    privLvl = 2'b11; featEn = 1'b0;
    #1 expectVal(3, 64'h0000_0000_0000_FFFF, "R9 open with feature off");
    tick();
    tick();
    doneFlag = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!doneFlag && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule